// File: doc/BRIEF.md
# Rotate and Raster-Op Write Path

This block forms the write-data path of a frame buffer organised as four byte-wide planes. A configuration register, reached through an indexed register port, holds a three-bit right-rotate amount and a two-bit logic operation selector. When the processor writes a byte, the block first rotates that byte right by the programmed amount. For each plane, it then merges the rotated byte with that plane's byte in the read latch, using the selected operation. The four resulting bytes are presented together, one clock later, as the data to be stored.

The read latch is 32 bits wide and holds one byte per plane. Every processor read loads it with the four plane bytes fetched from memory. This lets software run read-modify-write sequences such as masking, setting or toggling pixels across all planes with a single write. Plane p occupies bits 8p+7 down to 8p of both the latch input and the plane output bus.

Top module: `rop_write_path`

## Requirements
- R1: After a synchronous active-low reset, the rotate amount and the operation are both zero. Reading index 03h returns 8'h00, `plane_wvalid` is 0 and `plane_wdata` is 0.
- R2: A register write with `cfg_index` = 8'h03 stores `cfg_wdata[2:0]` as the rotate amount and `cfg_wdata[4:3]` as the operation. Readback at index 03h returns {3'b000, operation, amount}. Bits 7:5 always read 0, writes to any other index change nothing, and readback at any other index returns 8'h00.
- R3: The written byte is rotated right by the amount (0 to 7): result bit i is input bit (i + amount) mod 8.
- R4: Operation 2'b00 stores the rotated byte unchanged in every plane.
- R5: Operation 2'b01 stores, in each plane p, the rotated byte ANDed with latch byte p.
- R6: Operation 2'b10 stores, in each plane p, the rotated byte ORed with latch byte p.
- R7: Operation 2'b11 stores, in each plane p, the rotated byte XORed with latch byte p.
- R8: The latch takes all 32 bits of `rd_planes` on every clock edge where `cpu_rd_en` is high, and it holds its value otherwise, writes included. A write in the same cycle as a read uses the latch contents from before that read.
- R9: `plane_wvalid` and `plane_wdata` are registered. They reflect the write strobed at the previous edge and use the configuration as it stood before that edge. In a cycle after an edge without a write, `plane_wvalid` is 0 and `plane_wdata` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_index | input | 8 | Register index for write and readback |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Combinational readback of the indexed register |
| cpu_rd_en | input | 1 | Processor read: load latch from `rd_planes` |
| rd_planes | input | 32 | Four plane bytes fetched by the read |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write byte |
| plane_wvalid | output | 1 | Plane data valid, one cycle after a write |
| plane_wdata | output | 32 | Four plane bytes to be stored |

## Verification
Register readback is combinational, so the bench checks it in the cycle after the write edge, once the new value is in place. Latch loads take effect at the read edge and show up only through the next write. A write result appears on `plane_wdata` right after the edge that samples `cpu_wr_en`. The bench therefore drives every input at the falling edge and checks the outputs at the following falling edge. It checks once more a cycle later, to confirm that `plane_wvalid` has dropped and the data is held.

// File: rtl/rop_pkg.sv
// Package: shared widths and the raster-op encoding for the write path.
// Assumes a byte-wide processor bus and four planes; the op codes are
// software-visible, so their values must not change.
package rop_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned PLANES  = 4;
    localparam int unsigned CNT_W   = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ROP_PASS = 2'b00,
        ROP_AND  = 2'b01,
        ROP_OR   = 2'b10,
        ROP_XOR  = 2'b11
    } rop_op_e;
endpackage

// File: rtl/rop_cfg_reg.sv
// Module: rotate/op configuration register behind an indexed port.
// Holds the rotate amount in bits CNT_W-1:0 and the op in the next two
// bits; higher bits are reserved and read zero. Assumes CNT_W+2 <= DATA_W.
module rop_cfg_reg
    import rop_pkg::*;
#(
    parameter int unsigned DW     = 8,
    parameter int unsigned CW     = 3,
    parameter int unsigned IDX_W  = 8,
    parameter logic [7:0]  REG_IX = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] index,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [CW-1:0]    rot_amt,
    output rop_op_e          op_sel
);
    localparam int unsigned OP_LSB = CW;
    localparam int unsigned USED_W = CW + 2;

    logic hit;
    logic unused_hi;

    // Decode whether the port targets this register.
    assign hit = (index == IDX_W'(REG_IX));

    // Reserved write bits are deliberately dropped.
    assign unused_hi = ^wdata[DW-1:USED_W];

    // Capture amount and op on a matching write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_amt <= '0;
            op_sel  <= ROP_PASS;
        end else if (wr_en && hit) begin
            rot_amt <= wdata[CW-1:0];
            op_sel  <= rop_op_e'(wdata[OP_LSB+1:OP_LSB]);
        end
    end

    // Readback with reserved bits forced to zero.
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[CW-1:0]          = rot_amt;
            rdata[OP_LSB+1:OP_LSB] = op_sel;
        end
    end
endmodule

// File: rtl/rop_rotator.sv
// Module: combinational right-rotate of a W-bit word by a variable amount.
// Assumes the amount is less than W.
module rop_rotator #(
    parameter int unsigned W  = 8,
    parameter int unsigned SW = 3
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] doubled;

    // Shift a doubled copy so bits wrap around from the top.
    always_comb begin
        doubled = {din, din} >> amt;
        dout    = doubled[W-1:0];
    end
endmodule

// File: rtl/rop_logic_unit.sv
// Module: per-plane raster operation of the rotated byte with the latch.
// Each plane uses only its own latch byte; purely combinational.
module rop_logic_unit
    import rop_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned NP = 4
) (
    input  logic [W-1:0]    src,
    input  logic [NP*W-1:0] latch,
    input  rop_op_e         op,
    output logic [NP*W-1:0] result
);
    for (genvar p = 0; p < NP; p++) begin : g_plane
        logic [W-1:0] lb;
        assign lb = latch[p*W +: W];

        // Select the operation for this plane's byte.
        always_comb begin
            unique case (op)
                ROP_AND: result[p*W +: W] = src & lb;
                ROP_OR:  result[p*W +: W] = src | lb;
                ROP_XOR: result[p*W +: W] = src ^ lb;
                default: result[p*W +: W] = src;
            endcase
        end
    end
endmodule

// File: rtl/rop_read_latch.sv
// Module: multi-plane read latch, loaded on each processor read.
// Holds its contents through writes; cleared on reset.
module rop_read_latch #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    // Capture all planes on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/rop_write_path.sv
// Module: top of the rotate and raster-op write path.
// Rotates the processor byte, merges it per plane with the read latch and
// registers the four plane bytes. A write uses the configuration and latch
// as they stood before its clock edge.
module rop_write_path
    import rop_pkg::*;
#(
    parameter int unsigned DW     = rop_pkg::DATA_W,
    parameter int unsigned NP     = rop_pkg::PLANES,
    parameter logic [7:0]  REG_IX = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [7:0]       cfg_index,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             cpu_rd_en,
    input  logic [NP*DW-1:0] rd_planes,
    input  logic             cpu_wr_en,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             plane_wvalid,
    output logic [NP*DW-1:0] plane_wdata
);
    localparam int unsigned CW  = $clog2(DW);
    localparam int unsigned BUS = NP * DW;

    logic [CW-1:0]  rot_amt;
    rop_op_e        op_sel;
    logic [BUS-1:0] latch_q;
    logic [DW-1:0]  rotated;
    logic [BUS-1:0] merged;

    rop_cfg_reg #(.DW(DW), .CW(CW), .IDX_W(8), .REG_IX(REG_IX)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .index(cfg_index),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .rot_amt(rot_amt), .op_sel(op_sel)
    );

    rop_read_latch #(.WIDTH(BUS)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(cpu_rd_en), .din(rd_planes), .q(latch_q)
    );

    rop_rotator #(.W(DW), .SW(CW)) u_rot (
        .din(cpu_wdata), .amt(rot_amt), .dout(rotated)
    );

    rop_logic_unit #(.W(DW), .NP(NP)) u_lu (
        .src(rotated), .latch(latch_q), .op(op_sel), .result(merged)
    );

    // Register the merged plane data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane_wvalid <= 1'b0;
            plane_wdata  <= '0;
        end else begin
            plane_wvalid <= cpu_wr_en;
            if (cpu_wr_en) plane_wdata <= merged;
        end
    end
endmodule

// File: rtl/rop_write_path_chk.sv
// Checker: temporal properties of the write path, bound into the top.
module rop_write_path_chk #(
    parameter int unsigned DW = 8,
    parameter int unsigned NP = 4,
    parameter int unsigned CW = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [7:0]       cfg_index,
    input logic [DW-1:0]    cfg_rdata,
    input logic             cpu_rd_en,
    input logic             cpu_wr_en,
    input logic [DW-1:0]    cpu_wdata,
    input logic             plane_wvalid,
    input logic [NP*DW-1:0] plane_wdata,
    input logic [CW-1:0]    rot_amt,
    input logic [1:0]       op_sel,
    input logic [NP*DW-1:0] latch_q
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DW-1:CW+2] == '0);

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && cfg_index == 8'h03) |=> ($stable(rot_amt) && $stable(op_sel)));

    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd_en |=> $stable(latch_q));

    a_r9_valid_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_en |=> plane_wvalid);

    a_r9_valid_only_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr_en |=> (!plane_wvalid && $stable(plane_wdata)));

    a_r4_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && rot_amt == '0 && op_sel == 2'b00)
            |=> plane_wdata == {NP{$past(cpu_wdata)}});
endmodule

bind rop_write_path rop_write_path_chk #(.DW(DW), .NP(NP), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_index(cfg_index),
    .cfg_rdata(cfg_rdata), .cpu_rd_en(cpu_rd_en), .cpu_wr_en(cpu_wr_en),
    .cpu_wdata(cpu_wdata), .plane_wvalid(plane_wvalid), .plane_wdata(plane_wdata),
    .rot_amt(rot_amt), .op_sel(op_sel), .latch_q(latch_q)
);

// File: tb/test_rop_write_path.sv
`timescale 1ns/1ps
module test_rop_write_path;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_index = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        cpu_rd_en = 1'b0;
    logic [31:0] rd_planes = 32'h0;
    logic        cpu_wr_en = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        plane_wvalid;
    logic [31:0] plane_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0]  m_amt = 3'd0;
    logic [1:0]  m_op = 2'd0;
    logic [31:0] m_latch = 32'h0;

    always #5 clk = ~clk;

    rop_write_path i_rop_write_path (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_index(cfg_index),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_rd_en(cpu_rd_en),
        .rd_planes(rd_planes), .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
        .plane_wvalid(plane_wvalid), .plane_wdata(plane_wdata)
    );

    function automatic logic [7:0] rotr(input logic [7:0] b, input logic [2:0] n);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[(i + n) % 8];
        return r;
    endfunction

    function automatic logic [31:0] expect_planes(input logic [7:0] b, input logic [2:0] n,
                                                  input logic [1:0] op, input logic [31:0] lat);
        logic [31:0] o;
        logic [7:0] r;
        r = rotr(b, n);
        for (int p = 0; p < 4; p++) begin
            case (op)
                2'b01:   o[p*8 +: 8] = r & lat[p*8 +: 8];
                2'b10:   o[p*8 +: 8] = r | lat[p*8 +: 8];
                2'b11:   o[p*8 +: 8] = r ^ lat[p*8 +: 8];
                default: o[p*8 +: 8] = r;
            endcase
        end
        return o;
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R4";
            2'b01: return "R5";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_index = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (idx == 8'h03) begin m_amt = val[2:0]; m_op = val[4:3]; end
        if (idx != 8'h03) begin
            #1 check("R2 other index reads zero", {24'h0, cfg_rdata}, 32'h0);
        end
        cfg_index = 8'h03;
        #1 check("R2 readback", {24'h0, cfg_rdata}, {24'h0, 3'b000, m_op, m_amt});
    endtask

    task automatic cpu_read(input logic [31:0] d);
        @(negedge clk);
        cpu_rd_en = 1'b1; rd_planes = d;
        @(negedge clk);
        cpu_rd_en = 1'b0;
        m_latch = d;
    endtask

    // Write, optionally with a simultaneous read; checks result and hold.
    task automatic cpu_write(input logic [7:0] b, input bit with_rd, input logic [31:0] d);
        logic [31:0] exp;
        exp = expect_planes(b, m_amt, m_op, m_latch);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_wdata = b;
        if (with_rd) begin cpu_rd_en = 1'b1; rd_planes = d; end
        @(negedge clk);
        cpu_wr_en = 1'b0; cpu_rd_en = 1'b0;
        if (with_rd) m_latch = d;
        check({"R3 R9 ", op_tag(m_op), with_rd ? " R8 old latch" : ""}, plane_wdata, exp);
        check("R9 valid", {31'h0, plane_wvalid}, 32'h1);
        @(negedge clk);
        check("R9 valid drop", {31'h0, plane_wvalid}, 32'h0);
        check("R9 data held", plane_wdata, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cfg_index = 8'h03;
        #1;
        check("R1 cfg zero", {24'h0, cfg_rdata}, 32'h0);
        check("R1 valid low", {31'h0, plane_wvalid}, 32'h0);
        check("R1 data zero", plane_wdata, 32'h0);

        // R1: reset config is a plain write (latch cleared too).
        cpu_write(8'hA5, 1'b0, 32'h0);

        // R2: reserved bits read zero, other indices ignored.
        cfg_write(8'h03, 8'hFF);
        cfg_write(8'h02, 8'h00);
        cfg_write(8'h04, 8'h00);
        cfg_write(8'h03, 8'h00);

        // R3: every rotate amount with a pass-through op.
        for (int n = 0; n < 8; n++) begin
            cfg_write(8'h03, {5'b0, 3'(n)});
            cpu_write(8'h81, 1'b0, 32'h0);
            cpu_write(8'h3C, 1'b0, 32'h0);
        end

        // R4..R7: each op against a distinct per-plane latch.
        cpu_read(32'hF00F_AA55);
        for (int op = 0; op < 4; op++) begin
            cfg_write(8'h03, {3'b0, 2'(op), 3'd0});
            cpu_write(8'hCC, 1'b0, 32'h0);
            cfg_write(8'h03, {3'b0, 2'(op), 3'd5});
            cpu_write(8'h96, 1'b0, 32'h0);
        end

        // R8: writes leave the latch alone; read+write uses the old latch.
        cfg_write(8'h03, 8'h08);
        cpu_write(8'hFF, 1'b0, 32'h0);
        cpu_write(8'hFF, 1'b0, 32'h0);
        cpu_write(8'hFF, 1'b1, 32'h1234_5678);
        cpu_write(8'hFF, 1'b0, 32'h0);

        // Constrained random mix.
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 2)      cfg_write(($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h03, 8'($urandom));
            else if (sel < 4) cpu_read($urandom);
            else if (sel < 5) cpu_write(8'($urandom), 1'b1, $urandom);
            else              cpu_write(8'($urandom), 1'b0, 32'h0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule